// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel that sits next to a free-running up-counter it does not own. Software sets it to one of two jobs. In the first, the channel watches an input pin and records the counter value when a chosen edge arrives. In the second, it compares the counter against a programmed value and drives an output pin. The counter value and the time-base update pulse come in as ports.

The channel value is held in two registers. The bus-visible one is the staging register; the other is the working register. The copy between them runs in opposite directions in the two jobs:

- **Capture:** the working register grabs the counter, and the staging register then receives it for software to read.
- **Compare:** the staging register feeds the working register. This copy happens either at once or only on an update pulse. The working register drives the comparator.

A pending capture raises a flag and, if enabled, an interrupt request. A capture that lands on an unread result also raises an over-capture flag.

The bus has three word addresses:

- **Control (0):**
  - bits [1:0] job select
  - bit 2 polarity
  - bit 3 channel enable
  - bit 4 staging enable
  - bit 5 waveform select (0 = toggle on match, 1 = PWM)
  - bit 6 interrupt enable
- **Status (1):**
  - bit 0 capture flag
  - bit 1 over-capture flag
- **Value (2):** the staging register.

Top module: `tcc_channel`

## Requirements
- R1: After reset, control, status and value read back as 0, and `ch_o` and `irq_o` are 0.
- R2: Bus reads and writes at the value address reach only the staging register. A value written while the working register is held still reads back at once.
- R3: With job select nonzero, channel enable 1 and polarity 0, a rising edge of `chan_i` latches `cnt_i` from that edge cycle into the working register. Two clock edges after the edge is first sampled, the value is in the staging register and status bit 0 is set. A bus read of the value address in this job clears status bit 0.
- R4: With polarity 1 in capture, only falling edges of `chan_i` capture; rising edges leave status and value untouched.
- R5: `irq_o` is high exactly when status bit 0 and control bit 6 are both set.
- R6: A capture that completes while status bit 0 is already set also sets status bit 1. Reading the value clears bit 0 but not bit 1.
- R7: Writing status with bit 1 at 0 clears the over-capture flag (bit 0 at 0 clears the capture flag, and 1s change nothing). Clearing the over-capture flag beats a capture completing in the same cycle.
- R8: In compare (job select 00) with staging enable 0, the working register takes the staging value one cycle after it changes. `cmp_eq_o` is high when `cnt_i` equals the working register, and `cmp_gt_o` when `cnt_i` is greater.
- R9: In compare with staging enable 1, the working register changes only on a clock edge where `upd_i` is high.
- R10: With waveform select 0, the internal reference inverts on each clock edge at which `cmp_eq_o` is high, and holds otherwise.
- R11: With waveform select 1, the reference is registered as 1 when `cnt_i` is below the working register, and 0 otherwise.
- R12: `ch_o` is the reference XOR the polarity bit while the channel is enabled, and 0 while it is disabled.
- R13: Job select 00 is compare and never captures. Any other code (01, 10, 11) is capture, and there the reference is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cnt_i | input | CNT_W | Counter value from the time base |
| upd_i | input | 1 | Update pulse from the time base |
| chan_i | input | 1 | Channel input pin |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from address |
| cmp_gt_o | output | 1 | Counter greater than working register |
| cmp_eq_o | output | 1 | Counter equal to working register |
| ch_o | output | 1 | Channel output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench checks that a captured value is the counter from the edge cycle, not a later one. A design that latched one cycle late, or wrote the staging register directly, would return the next count.

It checks that the wrong edge is ignored in each polarity. It also checks that the over-capture flag survives a read, and that clearing it wins against a capture in the same cycle. A design with the priority reversed would leave bit 1 set.

In compare, it checks that a staged value does not reach the comparator until the update pulse. It also checks that toggling happens only on match cycles, and that the PWM level flips exactly at the compare value. An early copy or an off-by-one compare would show up on `cmp_eq_o` or `ch_o`.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   localparam int ADDR_W = 2;
   localparam int CTRL_W = 7;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL = 2'd0,
      A_STAT = 2'd1,
      A_VAL  = 2'd2
   } reg_addr_e;

   // packed order gives bit positions: sel[1:0], pol 2, en 3, pre_en 4, pwm 5, ie 6
   typedef struct packed {
      logic       ie;
      logic       pwm;
      logic       pre_en;
      logic       en;
      logic       pol;
      logic [1:0] sel;
   } ctrl_t;
endpackage

// File: rtl/tcc_edge.sv
module tcc_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic pol,
   input  logic sig_i,
   output logic hit_o
);
   logic s_w;
   logic prev_q;

   initial begin
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $error("tcc_edge: SYNC_STAGES out of range");
   end

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign s_w = sig_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '0;
            else begin
               sq[0] <= sig_i;
               for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
            end
         end
         assign s_w = sq[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= s_w;
   end

   logic rise_w, fall_w;
   assign rise_w = s_w & ~prev_q;
   assign fall_w = ~s_w & prev_q;
   assign hit_o  = arm & (pol ? fall_w : rise_w);
endmodule

// File: rtl/tcc_cmp.sv
module tcc_cmp #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic         pwm,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmpv,
   output logic         gt_o,
   output logic         eq_o,
   output logic         ref_o
);
   logic ref_q;

   initial begin
      if (W < 2) $error("tcc_cmp: W too small");
   end

   assign gt_o = cnt > cmpv;
   assign eq_o = cnt == cmpv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ref_q <= 1'b0;
      else if (!active) ref_q <= 1'b0;
      else if (pwm)     ref_q <= (cnt < cmpv);
      else if (eq_o)    ref_q <= ~ref_q;
   end

   assign ref_o = ref_q;

   // R10: toggle waveform holds when no match
   a_r10_hold_without_match: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !pwm && !eq_o) |=> $stable(ref_o));
endmodule

// File: rtl/tcc_out.sv
module tcc_out #(
   parameter bit REG_OUT = 1'b0,
   parameter bit IDLE    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   input  logic pol,
   input  logic en,
   output logic pin_o
);
   logic drive_w;
   assign drive_w = en ? (ref_i ^ pol) : IDLE;

   generate
      if (REG_OUT) begin : g_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin_q <= IDLE;
            else        pin_q <= drive_w;
         end
         assign pin_o = pin_q;
      end else begin : g_comb
         assign pin_o = drive_w;
      end
   endgenerate
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
   import tcc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BUS_W       = 32,
   parameter int SYNC_STAGES = 0,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             upd_i,
   input  logic             chan_i,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             cmp_gt_o,
   output logic             cmp_eq_o,
   output logic             ch_o,
   output logic             irq_o
);
   initial begin
      if (BUS_W < CNT_W)  $error("tcc_channel: BUS_W below CNT_W");
      if (BUS_W < CTRL_W) $error("tcc_channel: BUS_W below control width");
      if (CNT_W < 2)      $error("tcc_channel: CNT_W too small");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] stage_q;
   logic [CNT_W-1:0] work_q;
   logic             cap_pend_q;
   logic             ccif_q;
   logic             ovf_q;
   logic             hit_w;
   logic             ref_w;

   logic in_mode, out_mode;
   assign out_mode = (ctrl_q.sel == 2'b00);
   assign in_mode  = ~out_mode;

   logic wr_ctrl, wr_stat, wr_val, rd_val;
   assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
   assign wr_stat = bus_wr && (bus_addr == A_STAT);
   assign wr_val  = bus_wr && (bus_addr == A_VAL);
   assign rd_val  = bus_rd && (bus_addr == A_VAL);

   logic clr_ccif, clr_ovf;
   assign clr_ccif = wr_stat && !bus_wdata[0];
   assign clr_ovf  = wr_stat && !bus_wdata[1];

   tcc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (in_mode & ctrl_q.en),
      .pol   (ctrl_q.pol),
      .sig_i (chan_i),
      .hit_o (hit_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
   end

   // working register: counter in on capture, staging in on compare
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) work_q <= '0;
      else if (in_mode) begin
         if (hit_w) work_q <= cnt_i;
      end else if (!ctrl_q.pre_en || upd_i) begin
         work_q <= stage_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_pend_q <= 1'b0;
      else        cap_pend_q <= hit_w;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stage_q <= '0;
      else if (cap_pend_q) stage_q <= work_q;
      else if (wr_val)     stage_q <= bus_wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ccif_q <= 1'b0;
      else if (cap_pend_q)        ccif_q <= 1'b1;
      else if (clr_ccif)          ccif_q <= 1'b0;
      else if (rd_val && in_mode) ccif_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ovf_q <= 1'b0;
      else if (clr_ovf)              ovf_q <= 1'b0;
      else if (cap_pend_q && ccif_q) ovf_q <= 1'b1;
   end

   tcc_cmp #(.W(CNT_W)) u_cmp (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (out_mode),
      .pwm    (ctrl_q.pwm),
      .cnt    (cnt_i),
      .cmpv   (work_q),
      .gt_o   (cmp_gt_o),
      .eq_o   (cmp_eq_o),
      .ref_o  (ref_w)
   );

   tcc_out #(.REG_OUT(REG_OUT), .IDLE(1'b0)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_i (ref_w),
      .pol   (ctrl_q.pol),
      .en    (ctrl_q.en),
      .pin_o (ch_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_CTRL:  bus_rdata[CTRL_W-1:0] = ctrl_q;
         A_STAT:  bus_rdata[1:0]        = {ovf_q, ccif_q};
         A_VAL:   bus_rdata[CNT_W-1:0]  = stage_q;
         default: bus_rdata             = '0;
      endcase
   end

   assign irq_o = ctrl_q.ie & ccif_q;

   // R3: a completing capture always leaves the flag set
   a_r3_flag_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_pend_q |=> ccif_q);

   // R6: capture on an unread result raises over-capture
   a_r6_overcapture: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_pend_q && ccif_q && !clr_ovf) |=> ovf_q);

   // R7: clearing over-capture wins in the same cycle
   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ovf |=> !ovf_q);

   // R9: staged compare value holds without an update pulse
   a_r9_hold_working: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode && ctrl_q.pre_en && !upd_i) |=> $stable(work_q));

   // R13: compare job never detects a capture edge
   a_r13_no_capture_in_compare: assert property (@(posedge clk) disable iff (!rst_n)
      out_mode |-> !hit_w);
endmodule

// File: tb/sim_tcc_channel.sv
module sim_tcc_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_i = '0;
   logic        upd_i = 1'b0;
   logic        chan_i = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cmp_gt_o, cmp_eq_o, ch_o, irq_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   tcc_channel u0 (
      .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i), .chan_i(chan_i),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cmp_gt_o(cmp_gt_o), .cmp_eq_o(cmp_eq_o),
      .ch_o(ch_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bw(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic br(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic pulse_in(input logic [15:0] c);
      @(negedge clk);
      chan_i = ~chan_i; cnt_i = c;
      @(negedge clk);
      cnt_i = c + 16'd50;
      @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      br(2'd0, d); chk("R1 ctrl", d, 0);
      br(2'd1, d); chk("R1 stat", d, 0);
      br(2'd2, d); chk("R1 val", d, 0);
      chk("R1 ch_o", ch_o, 0);
      chk("R1 irq", irq_o, 0);
   endtask

   task automatic t_capture_rise;
      logic [31:0] d;
      bw(2'd0, 32'h49);
      pulse_in(16'd100);           // rising at cnt 100
      chk("R5 irq set", irq_o, 1);
      br(2'd1, d); chk("R3 stat after capture", d, 1);
      br(2'd2, d); chk("R3 captured value", d, 100);
      br(2'd1, d); chk("R3 read clears flag", d, 0);
      pulse_in(16'd150);           // falling, ignored with polarity 0
      br(2'd1, d); chk("R4 falling ignored pol0", d, 0);
      br(2'd2, d); chk("R4 value kept pol0", d, 100);
   endtask

   task automatic t_capture_fall;
      logic [31:0] d;
      bw(2'd0, 32'h4D);
      pulse_in(16'd300);           // rising, ignored with polarity 1
      br(2'd1, d); chk("R4 rising ignored pol1", d, 0);
      pulse_in(16'd400);           // falling captures
      br(2'd1, d); chk("R4 falling flag", d, 1);
      br(2'd2, d); chk("R4 falling value", d, 400);
   endtask

   task automatic t_overcapture;
      logic [31:0] d;
      bw(2'd0, 32'h49);
      pulse_in(16'd10); pulse_in(16'd11);
      pulse_in(16'd20); pulse_in(16'd21);
      br(2'd1, d); chk("R6 both flags", d, 3);
      br(2'd2, d); chk("R6 newest value", d, 20);
      br(2'd1, d); chk("R6 ovf survives read", d, 2);
      bw(2'd1, 32'h1);
      br(2'd1, d); chk("R7 ovf cleared", d, 0);
      pulse_in(16'd30); pulse_in(16'd31);
      // capture completes in the same cycle as the clear write
      @(negedge clk); chan_i = 1'b1; cnt_i = 16'd40;
      @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h1;
      @(negedge clk); bus_wr = 1'b0;
      br(2'd1, d); chk("R7 clear beats capture", d, 1);
      bw(2'd0, 32'h09);
      #1 chk("R5 irq masked", irq_o, 0);
      br(2'd2, d); chk("R7 value from tie cycle", d, 40);
      chan_i = 1'b0;
      bw(2'd1, 32'h0);
   endtask

   task automatic t_mode_sel;
      logic [31:0] d;
      bw(2'd0, 32'h08);
      pulse_in(16'd77); pulse_in(16'd78);
      br(2'd1, d); chk("R13 no capture in compare", d, 0);
      br(2'd2, d); chk("R13 value untouched", d, 40);
      bw(2'd0, 32'h0B);
      pulse_in(16'd55); pulse_in(16'd56);
      br(2'd2, d); chk("R13 code 11 captures", d, 55);
      bw(2'd0, 32'h0A);
      pulse_in(16'd66); pulse_in(16'd67);
      br(2'd2, d); chk("R13 code 10 captures", d, 66);
      bw(2'd1, 32'h0);
   endtask

   task automatic t_compare_imm;
      logic [31:0] d;
      cnt_i = 16'd0;
      bw(2'd0, 32'h00);
      bw(2'd2, 32'd50);
      @(negedge clk); cnt_i = 16'd50;
      #1 chk("R8 eq", cmp_eq_o, 1); chk("R8 gt low at eq", cmp_gt_o, 0);
      cnt_i = 16'd51;
      #1 chk("R8 gt", cmp_gt_o, 1); chk("R8 eq low above", cmp_eq_o, 0);
      cnt_i = 16'd49;
      #1 chk("R8 below", {cmp_gt_o, cmp_eq_o}, 0);
      br(2'd2, d); chk("R2 readback", d, 50);
   endtask

   task automatic t_preload;
      logic [31:0] d;
      cnt_i = 16'd0;
      bw(2'd0, 32'h10);
      bw(2'd2, 32'd80);
      repeat (3) @(negedge clk);
      cnt_i = 16'd80;
      #1 chk("R9 not copied yet", cmp_eq_o, 0);
      cnt_i = 16'd50;
      #1 chk("R9 old value active", cmp_eq_o, 1);
      br(2'd2, d); chk("R2 staged readback", d, 80);
      @(negedge clk); upd_i = 1'b1;
      @(negedge clk); upd_i = 1'b0; cnt_i = 16'd80;
      #1 chk("R9 copied on update", cmp_eq_o, 1);
   endtask

   task automatic t_toggle;
      cnt_i = 16'd0;
      bw(2'd0, 32'h01);            // capture job resets reference
      bw(2'd0, 32'h08);
      bw(2'd2, 32'd5);
      @(negedge clk);
      chk("R10 start low", ch_o, 0);
      cnt_i = 16'd5;
      @(negedge clk); cnt_i = 16'd6;
      chk("R10 toggled on match", ch_o, 1);
      repeat (3) @(negedge clk);
      chk("R10 held off match", ch_o, 1);
      cnt_i = 16'd5;
      @(negedge clk); cnt_i = 16'd6;
      chk("R10 toggled back", ch_o, 0);
      bw(2'd0, 32'h0C);
      chk("R12 inverted polarity", ch_o, 1);
      bw(2'd0, 32'h04);
      chk("R12 disabled idle", ch_o, 0);
   endtask

   task automatic t_pwm;
      bw(2'd0, 32'h28);
      cnt_i = 16'd3;
      @(negedge clk); chk("R11 below high", ch_o, 1);
      cnt_i = 16'd5;
      @(negedge clk); chk("R11 at value low", ch_o, 0);
      cnt_i = 16'd9;
      @(negedge clk); chk("R11 above low", ch_o, 0);
      cnt_i = 16'd4;
      @(negedge clk); chk("R11 just below high", ch_o, 1);
      bw(2'd0, 32'h2C);
      chk("R12 pwm inverted", ch_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_capture_rise();
      t_capture_fall();
      chan_i = 1'b0;
      t_overcapture();
      t_mode_sel();
      t_compare_imm();
      t_preload();
      t_toggle();
      t_pwm();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule